// File: doc/BRIEF.md
# Symmetric Decimating FIR Filter

This block smooths a stream of 16-bit frequency samples with a run-time configurable FIR filter and emits one filtered result for every N accepted samples. A single multiply-accumulate unit is shared across all taps. It works through the taps one per clock, so the number of taps that can be computed grows with the decimation factor. In symmetric mode, mirrored samples are first combined by a pre-adder: they are added for even symmetry and subtracted for odd symmetry. This folds a filter of up to 63 taps onto at most 32 coefficients. In asymmetric mode each stored coefficient weights exactly one sample, which limits that mode to 32 taps.

The filter is set up through an 11-bit configuration word, with its bits numbered 13 down to 3. Coefficients are loaded into a 32-entry register bank through a simple write port. When a result is due, the delay line is copied into a snapshot. The accumulation reads only that snapshot, so new input samples can keep arriving while a result is being computed. If a new result becomes due before the previous one has finished, the new one is dropped and a sticky flag records the overrun.

Top module: `symdec_fir`

## Requirements
- R1: Configuration word fields are as follows. Bits 8:3 hold the tap count L, and a value of 0 behaves as 1. Bit 9 set selects symmetric mode; clear selects asymmetric mode. Bit 10 set selects odd symmetry (mirrored samples are subtracted). Bits 13:11 hold the decimation code.
- R2: A result is started on every (code+1)-th accepted sample, counted from reset. The sample that completes the count is included in that result.
- R3: In symmetric mode with even symmetry, the result is the sum over k < ceil(L/2) of c[k]·(x[k]+x[L-1-k]). Here x[0] is the newest sample and c[k] is the coefficient at bank address k.
- R4: With odd symmetry selected, each mirrored pair contributes c[k]·(x[k]-x[L-1-k]).
- R5: When L is odd in symmetric mode, the centre tap contributes c[(L-1)/2]·x[(L-1)/2] alone, for either symmetry.
- R6: In asymmetric mode the result is the sum over k < min(L,32) of c[k]·x[k].
- R7: Coefficients are signed Q1.15. The full-precision sum S is output as floor((S+2^14)/2^15), saturated to the range -32768..32767.
- R8: A result takes M clock cycles, where M is ceil(L/2) in symmetric mode and min(L,32) in asymmetric mode. dout_valid is high for one cycle, M edges after the edge that accepted the triggering sample. dout holds its value until the next result.
- R9: A result that becomes due while another is in progress, other than on that one's final cycle, is dropped and sets overrun. overrun stays high until reset. A result that becomes due on the final cycle is accepted without an overrun.
- R10: When coef_we is high at a clock edge, coef_data is written to bank address coef_addr.
- R11: Reset clears dout, dout_valid, overrun, the sample history, the coefficient bank and the decimation count.
- R12: While din_valid is low, din is ignored: the history does not shift and the decimation count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 11 | Configuration, bits 13:3 (see R1) |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 5 | Coefficient bank address |
| coef_data | input | 16 | Signed Q1.15 coefficient |
| din | input | 16 | Signed input sample |
| din_valid | input | 1 | Input sample strobe |
| dout | output | 16 | Rounded, saturated filter result |
| dout_valid | output | 1 | One-cycle result strobe |
| overrun | output | 1 | Sticky dropped-result flag |

## Verification
The filter is run with pseudo-random samples and coefficients at even and odd tap counts, under both symmetries. A wrong pairing index, a wrong pre-add sign or a mishandled centre tap each change the result. Asymmetric runs, including a tap count above 32, separate the single-sample path from the folded path and confirm the clamp. Bursty input with junk data between strobes shows that only strobed samples shift the history or advance the decimation count. Three further cases are run: full-scale inputs that force saturation at both ends, half-LSB inputs that pin the rounding direction, and a job whose length exactly equals the decimation interval, set against one that is too long, to locate the overrun boundary.

// File: rtl/symfir_pkg.sv
package symfir_pkg;
    localparam int DATA_W   = 16;
    localparam int COEF_W   = 16;
    localparam int MAX_TAPS = 63;
    localparam int NCOEF    = (MAX_TAPS + 1) / 2;
    localparam int TAP_W    = $clog2(MAX_TAPS + 1);
    localparam int CIDX_W   = $clog2(NCOEF);
    localparam int DEC_W    = 3;
    localparam int PAIR_W   = DATA_W + 1;
    localparam int PROD_W   = PAIR_W + COEF_W;
    localparam int ACC_W    = PROD_W + CIDX_W + 1;
    localparam int FRAC_W   = COEF_W - 1;

    // Decoded job description
    typedef struct packed {
        logic [TAP_W-1:0] len;       // effective tap count
        logic [TAP_W-1:0] macs;      // MAC cycles per result
        logic             symmetric;
        logic             odd_sym;
        logic [DEC_W-1:0] dec;
    } mode_t;

    // Round half up at the Q1.15 point, then clamp to DATA_W bits
    function automatic logic [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] biased;
        logic signed [ACC_W-1:0] shifted;
        logic [ACC_W-DATA_W:0]   upper;
        biased  = acc + (ACC_W'(1) << (FRAC_W - 1));
        shifted = biased >>> FRAC_W;
        upper   = shifted[ACC_W-1:DATA_W-1];
        if ((&upper) || !(|upper))
            return shifted[DATA_W-1:0];
        else if (shifted[ACC_W-1])
            return {1'b1, {(DATA_W-1){1'b0}}};
        else
            return {1'b0, {(DATA_W-1){1'b1}}};
    endfunction
endpackage

// File: rtl/symfir_cfg_decode.sv
module symfir_cfg_decode
    import symfir_pkg::*;
(
    input  logic [13:3] cfg_word,
    output mode_t       mode
);
    logic [TAP_W-1:0] raw_len;
    logic [TAP_W-1:0] nz_len;
    logic [TAP_W:0]   half_up;

    always_comb begin
        raw_len        = cfg_word[8:3];
        nz_len         = (raw_len == '0) ? TAP_W'(1) : raw_len;
        half_up        = ({1'b0, nz_len} + 1'b1) >> 1;
        mode.symmetric = cfg_word[9];
        mode.odd_sym   = cfg_word[10];
        mode.dec       = cfg_word[13:11];
        if (cfg_word[9]) begin
            mode.len  = nz_len;
            mode.macs = half_up[TAP_W-1:0];
        end else begin
            mode.len  = (nz_len > TAP_W'(NCOEF)) ? TAP_W'(NCOEF) : nz_len;
            mode.macs = mode.len;
        end
        AST_MACS_BOUNDED: assert (mode.macs != '0 && mode.macs <= TAP_W'(NCOEF)); // R1
    end
endmodule

// File: rtl/symfir_coef_bank.sv
module symfir_coef_bank
    import symfir_pkg::*;
#(
    parameter int DEPTH = NCOEF,
    parameter int WIDTH = COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] word;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we)
            bank_d.word[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign rdata = bank_q.word[raddr];

    AST_COEF_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> bank_q.word[$past(waddr)] == $past(wdata)); // R10
endmodule

// File: rtl/symfir_sample_store.sv
module symfir_sample_store
    import symfir_pkg::*;
#(
    parameter int DEPTH = MAX_TAPS,
    parameter int WIDTH = DATA_W,
    parameter int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic [WIDTH-1:0]        din,
    input  logic                    load,
    input  logic [IDX_W-1:0]        rd_a,
    input  logic [IDX_W-1:0]        rd_b,
    input  logic                    use_b,
    input  logic                    subtract,
    output logic signed [WIDTH:0]   pair
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] line;   // live history, element 0 newest
        logic [DEPTH-1:0][WIDTH-1:0] snap;   // frozen copy for the running job
    } store_t;

    store_t                      st_d, st_q;
    logic [DEPTH-1:0][WIDTH-1:0] shifted;
    logic signed [WIDTH:0]       op_a, op_b;

    always_comb begin
        shifted = {st_q.line[DEPTH-2:0], din};
        st_d    = st_q;
        if (shift_en)
            st_d.line = shifted;
        if (load)
            st_d.snap = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // Pre-adder: mirrored pair, or a single sample when use_b is low
    always_comb begin
        op_a = {st_q.snap[rd_a][WIDTH-1], st_q.snap[rd_a]};
        op_b = use_b ? {st_q.snap[rd_b][WIDTH-1], st_q.snap[rd_b]} : '0;
        pair = subtract ? (op_a - op_b) : (op_a + op_b);
    end

    AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> st_q.line == $past(st_q.line)); // R12
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> st_q.snap == $past(st_q.snap)); // R9
endmodule

// File: rtl/symdec_fir.sv
module symdec_fir
    import symfir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [13:3]       cfg_word,
    input  logic              coef_we,
    input  logic [CIDX_W-1:0] coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              overrun
);
    typedef struct packed {
        logic [DEC_W-1:0]        phase;
        logic                    busy;
        logic [TAP_W-1:0]        idx;
        mode_t                   job;
        logic signed [ACC_W-1:0] acc;
        logic [DATA_W-1:0]       dout;
        logic                    dvalid;
        logic                    ovr;
    } ctl_t;

    ctl_t                     st_d, st_q;
    mode_t                    cfg_mode;
    logic [COEF_W-1:0]        coef_rd;
    logic signed [PAIR_W-1:0] pair;
    logic [TAP_W-1:0]         rd_b;
    logic                     use_b;
    logic                     last;
    logic                     trig;
    logic                     start;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_next;

    symfir_cfg_decode u_decode (
        .cfg_word (cfg_word),
        .mode     (cfg_mode)
    );

    symfir_coef_bank #(
        .DEPTH (NCOEF),
        .WIDTH (COEF_W)
    ) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (st_q.idx[CIDX_W-1:0]),
        .rdata (coef_rd)
    );

    symfir_sample_store #(
        .DEPTH (MAX_TAPS),
        .WIDTH (DATA_W),
        .IDX_W (TAP_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (din_valid),
        .din      (din),
        .load     (start),
        .rd_a     (st_q.idx),
        .rd_b     (rd_b),
        .use_b    (use_b),
        .subtract (st_q.job.odd_sym),
        .pair     (pair)
    );

    always_comb begin
        last     = st_q.busy && (st_q.idx == st_q.job.macs - 1'b1);
        trig     = din_valid && (st_q.phase >= cfg_mode.dec);
        start    = trig && (!st_q.busy || last);
        rd_b     = st_q.job.len - 1'b1 - st_q.idx;
        // centre tap of an odd-length folded filter stands alone
        use_b    = st_q.job.symmetric &&
                   !(st_q.job.len[0] && (st_q.idx == st_q.job.macs - 1'b1));
        prod     = $signed(coef_rd) * pair;
        acc_next = $signed(st_q.acc) + $signed({{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod});

        st_d        = st_q;
        st_d.dvalid = 1'b0;
        if (din_valid)
            st_d.phase = trig ? '0 : st_q.phase + 1'b1;

        if (st_q.busy) begin
            st_d.acc = acc_next;
            st_d.idx = st_q.idx + 1'b1;
            if (last) begin
                st_d.dout   = round_sat(acc_next);
                st_d.dvalid = 1'b1;
                st_d.busy   = 1'b0;
            end
        end

        if (trig) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.acc  = '0;
                st_d.job  = cfg_mode;
            end else begin
                st_d.ovr  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout       = st_q.dout;
    assign dout_valid = st_q.dvalid;
    assign overrun    = st_q.ovr;

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.idx < st_q.job.macs); // R8
    AST_VALID_AFTER_MAC: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dvalid |-> $past(st_q.busy)); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr); // R9
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(st_q.busy && din_valid)); // R9
    AST_ACC_HEADROOM: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.acc[ACC_W-1] == st_q.acc[ACC_W-2]); // R7
endmodule

// File: tb/tb_symdec_fir.sv
module tb_symdec_fir;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:3] cfg_word = '0;
    logic        coef_we = 1'b0;
    logic [4:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic [15:0] din = '0;
    logic        din_valid = 1'b0;
    logic [15:0] dout;
    logic        dout_valid;
    logic        overrun;

    always #(CLK_PERIOD/2) clk = ~clk;

    symdec_fir dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_data  (coef_data),
        .din        (din),
        .din_valid  (din_valid),
        .dout       (dout),
        .dout_valid (dout_valid),
        .overrun    (overrun)
    );

    // reference model state
    int hist[63];
    int mc[32];
    int m_phase, m_cnt, m_res, exp_d;
    bit m_busy, m_ovr, exp_v;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string req = "R11";
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'($signed(seed[31:16]));
    endfunction

    function automatic int ref_macs(int len_f, bit sym);
        int n = (len_f == 0) ? 1 : len_f;
        if (sym) return (n + 1) / 2;
        return (n > 32) ? 32 : n;
    endfunction

    function automatic int ref_filter(int len_f, bit sym, bit odd);
        int n = (len_f == 0) ? 1 : len_f;
        longint acc = 0;
        longint p, y;
        if (!sym) begin
            if (n > 32) n = 32;
            for (int k = 0; k < n; k++) acc += longint'(mc[k]) * hist[k];
        end else begin
            for (int k = 0; k < (n + 1) / 2; k++) begin
                int j = n - 1 - k;
                if (j == k)   p = hist[k];
                else if (odd) p = longint'(hist[k]) - hist[j];
                else          p = longint'(hist[k]) + hist[j];
                acc += longint'(mc[k]) * p;
            end
        end
        y = (acc + 16384) >>> 15;
        if (y > 32767)  y = 32767;
        if (y < -32768) y = -32768;
        return int'(y);
    endfunction

    always @(posedge clk) begin : model
        bit was_busy, fin, trig;
        if (!rst_n) begin
            foreach (hist[i]) hist[i] = 0;
            foreach (mc[i]) mc[i] = 0;
            m_phase = 0; m_cnt = 0; m_res = 0; exp_d = 0;
            m_busy = 0; m_ovr = 0; exp_v = 0;
        end else begin
            was_busy = m_busy;
            fin      = m_busy && (m_cnt == 1);
            trig     = 0;
            exp_v    = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    exp_v  = 1;
                    exp_d  = m_res;
                    m_busy = 0;
                end
            end
            if (coef_we) mc[coef_addr] = int'($signed(coef_data));
            if (din_valid) begin
                for (int i = 62; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = int'($signed(din));
                if (m_phase >= int'(cfg_word[13:11])) begin
                    m_phase = 0;
                    trig    = 1;
                end else begin
                    m_phase++;
                end
            end
            if (trig) begin
                if (was_busy && !fin) begin
                    m_ovr = 1;
                end else begin
                    m_res  = ref_filter(int'(cfg_word[8:3]), cfg_word[9], cfg_word[10]);
                    m_cnt  = ref_macs(int'(cfg_word[8:3]), cfg_word[9]);
                    m_busy = 1;
                end
            end
        end
    end

    task automatic chk(bit ok, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dout_valid == exp_v, "dout_valid", int'(dout_valid), int'(exp_v));
            chk(int'($signed(dout)) == exp_d, "dout", int'($signed(dout)), exp_d);
            chk(overrun == m_ovr, "overrun", int'(overrun), int'(m_ovr));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic send(int x);
        @(negedge clk);
        din_valid = 1'b1;
        din       = 16'(x);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            din_valid = 1'b0;
            din       = 16'(rnd16());
        end
    endtask

    task automatic stream(int count, int gap);
        for (int i = 0; i < count; i++) begin
            send(rnd16());
            if (gap > 0) idle(gap);
        end
    endtask

    task automatic wcoef(int a, int d);
        @(negedge clk);
        din_valid = 1'b0;
        coef_we   = 1'b1;
        coef_addr = 5'(a);
        coef_data = 16'(d);
        @(negedge clk);
        coef_we   = 1'b0;
    endtask

    task automatic setcfg(int n, bit sym, bit odd, int dec);
        cfg_word = {3'(dec), odd, sym, 6'(n)};
    endtask

    task automatic reset_check(string tag);
        @(negedge clk);
        din_valid = 1'b0;
        rst_n     = 1'b0;
        repeat (2) begin
            @(negedge clk);
            req = tag;
            chk(dout == 16'd0, "reset dout", int'(dout), 0);
            chk(dout_valid == 1'b0, "reset dout_valid", int'(dout_valid), 0);
            chk(overrun == 1'b0, "reset overrun", int'(overrun), 0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        reset_check("R11");

        req = "R10";
        for (int a = 0; a < 32; a++) wcoef(a, rnd16());
        idle(4);

        req = "R3";  setcfg(8, 1, 0, 3);  stream(40, 0); idle(40);
        req = "R5";  setcfg(7, 1, 0, 3);  stream(40, 0); idle(40);
        req = "R4";  setcfg(10, 1, 1, 4); stream(30, 0); idle(40);
        req = "R5";  setcfg(9, 1, 1, 4);  stream(30, 0); idle(40);
        req = "R6";  setcfg(20, 0, 0, 7); stream(40, 2); idle(40);
        req = "R6";  setcfg(45, 0, 1, 7); stream(40, 3); idle(60);
        req = "R2";  setcfg(2, 1, 0, 0);  stream(20, 0); idle(10);
        req = "R1";  setcfg(0, 1, 0, 1);  stream(20, 0); idle(10);
        req = "R12"; setcfg(5, 1, 0, 2);  stream(30, 1); idle(20);
        req = "R8";  setcfg(8, 0, 0, 7);  stream(48, 0); idle(20);   // job length equals interval

        req = "R7";
        for (int a = 0; a < 32; a++) wcoef(a, 32767);
        setcfg(16, 1, 0, 7);
        for (int i = 0; i < 24; i++) send(32767);
        idle(20);
        for (int i = 0; i < 24; i++) send(-32768);
        idle(20);
        for (int a = 0; a < 32; a++) wcoef(a, (a == 0) ? 1 : 0);
        setcfg(1, 0, 0, 0);
        send(16384); send(-16384); send(16383); send(-16385); send(49152 - 65536);
        idle(10);

        req = "R9";
        for (int a = 0; a < 32; a++) wcoef(a, rnd16());
        setcfg(63, 1, 0, 0);
        stream(10, 0);
        idle(60);

        reset_check("R9");
        req = "R11";
        for (int a = 0; a < 32; a++) wcoef(a, rnd16());
        setcfg(8, 0, 0, 0);
        send(12345);
        idle(20);

        finish_run();
    end
endmodule